// File: doc/BRIEF.md
# Buck Controller Fault Supervisor

This block is the digital protection manager that sits between a buck controller's analog comparators and its gate drivers. It watches four single-bit flags: feedback above the over-voltage trip, feedback below the under-voltage trip, supply above the rising lockout level, and supply above the falling lockout level. It also receives the enable input, a one-clock switching-cycle tick and the modulator's high-side and low-side requests. From these it decides what reaches the drivers and whether power-good is asserted.

Over-voltage is qualified by a time deglitch, counted in system clocks. Once accepted, it parks the output with the low-side switch held on. Under-voltage must be seen on a run of consecutive switching ticks. Once accepted, both drivers go to high impedance. Either fault stays latched until enable is taken low or the supply drops out and comes back. Supply lockout uses hysteresis: running starts above the rising level and stops below the falling level. The soft-start reset output is held asserted whenever the converter is not in normal operation, so that each fresh start begins from zero.

Top module: `buck_fault_supervisor`

## Requirements
- R1: While reset is high and on the first cycle after it, gates are low, both driver enables are low, power-good is low, soft-start reset is high and the fault code is 2'b00.
- R2: The supply is accepted when the rising-level flag is high and dropped when the falling-level flag is low, and is otherwise unchanged. While it is not accepted, both gates and both driver enables are low.
- R3: While running (supply accepted, enable high, no latched fault), the high-side gate follows its request and the low-side gate follows its request only when the high-side request is low. Both driver enables are high, and power-good is high only when neither feedback flag is set.
- R4: In the running state, the over-voltage flag must be high for OV_CYCLES consecutive clocks before a fault is taken, where OV_CYCLES = CLK_HZ/1000 * OV_DELAY_NS / 1e6. Any clock with the flag low restarts the count.
- R5: A latched over-voltage fault gives high-side gate low, low-side gate high, both driver enables high, power-good low and fault code 2'b01.
- R6: In the running state, the under-voltage flag is sampled only on switching ticks, and a fault is taken on the UV_TICKS-th consecutive tick with the flag high. A tick with the flag low restarts the count.
- R7: A latched under-voltage fault gives both gates low, both driver enables low, power-good low and fault code 2'b10.
- R8: A latched fault persists while enable stays high and the supply stays accepted, even after the flags clear. It is cleared by enable going low or by loss of the supply.
- R9: When both qualifications complete on the same clock, the over-voltage fault is latched.
- R10: The soft-start reset output is high in every state except running.
- R11: With the supply accepted and enable low, both drivers are tri-stated, the gates are low and the fault code is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_tick | input | 1 | One-clock pulse per switching cycle |
| fb_over | input | 1 | Feedback above over-voltage trip |
| fb_under | input | 1 | Feedback below under-voltage trip |
| vdd_above_rise | input | 1 | Supply above rising lockout level |
| vdd_above_fall | input | 1 | Supply above falling lockout level |
| enable | input | 1 | Converter enable |
| pwm_hs_req | input | 1 | Modulator high-side request |
| pwm_ls_req | input | 1 | Modulator low-side request |
| gate_hs | output | 1 | High-side gate command |
| gate_ls | output | 1 | Low-side gate command |
| drv_hs_oe | output | 1 | High-side driver enable (low = tri-state) |
| drv_ls_oe | output | 1 | Low-side driver enable (low = tri-state) |
| pgood | output | 1 | Power-good flag |
| ss_clear | output | 1 | Soft-start counter reset |
| fault_code | output | 2 | 00 none, 01 over-voltage, 10 under-voltage |

## Verification
The bench builds the block with CLK_HZ set to 4 MHz and OV_DELAY_NS left at 5000, which shrinks the deglitch to 20 clocks. That makes both the 19-clock near miss and the exact 20-clock trip cheap to exercise. UV_TICKS stays at its default of 8, so the under-voltage run is checked at its real length, including a restart after 7 ticks. The same settings allow over-voltage and under-voltage qualification to be lined up on one clock edge to test priority.

// File: rtl/bfs_pkg.sv
package bfs_pkg;

  typedef enum logic [2:0] {
    ST_LOCK = 3'd0,
    ST_OFF  = 3'd1,
    ST_RUN  = 3'd2,
    ST_OVP  = 3'd3,
    ST_UVP  = 3'd4
  } sup_state_t;

  typedef enum logic [1:0] {
    FC_NONE = 2'b00,
    FC_OVP  = 2'b01,
    FC_UVP  = 2'b10
  } fault_code_t;

  // Deglitch length in system clocks; never below one.
  function automatic int ov_cycles(input longint clk_hz, input longint delay_ns);
    longint c;
    c = (clk_hz / 1000) * delay_ns / 1000000;
    if (c < 1) c = 1;
    return int'(c);
  endfunction

endpackage

// File: rtl/bfs_supply_mon.sv
// Supply acceptance with hysteresis (R2).
module bfs_supply_mon (
  input  logic clk,
  input  logic rst,
  input  logic above_rise,
  input  logic above_fall,
  output logic ok_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ok_o <= 1'b0;
    end else if (!ok_o && above_rise) begin
      ok_o <= 1'b1;
    end else if (ok_o && !above_fall) begin
      ok_o <= 1'b0;
    end
  end

endmodule

// File: rtl/bfs_ov_deglitch.sv
// Time deglitch for the over-voltage flag (R4).
module bfs_ov_deglitch #(
  parameter int CYCLES = 500
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic flag,
  output logic hit
);

  localparam int W = $clog2(CYCLES + 1);
  localparam logic [W-1:0] LAST = W'(CYCLES - 1);

  logic [W-1:0] cnt;

  assign hit = arm && flag && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !arm || !flag) begin
      cnt <= '0;
    end else if (cnt != LAST) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/bfs_uv_counter.sv
// Consecutive switching-tick qualification for under-voltage (R6).
module bfs_uv_counter #(
  parameter int TICKS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic tick,
  input  logic flag,
  output logic hit
);

  localparam int W = $clog2(TICKS + 1);
  localparam logic [W-1:0] LAST = W'(TICKS - 1);

  logic [W-1:0] cnt;

  assign hit = arm && tick && flag && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !arm) begin
      cnt <= '0;
    end else if (tick) begin
      if (!flag) begin
        cnt <= '0;
      end else if (cnt != LAST) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/buck_fault_supervisor.sv
module buck_fault_supervisor #(
  parameter longint CLK_HZ      = 100000000,
  parameter longint OV_DELAY_NS = 5000,
  parameter int     UV_TICKS    = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sw_tick,
  input  logic       fb_over,
  input  logic       fb_under,
  input  logic       vdd_above_rise,
  input  logic       vdd_above_fall,
  input  logic       enable,
  input  logic       pwm_hs_req,
  input  logic       pwm_ls_req,
  output logic       gate_hs,
  output logic       gate_ls,
  output logic       drv_hs_oe,
  output logic       drv_ls_oe,
  output logic       pgood,
  output logic       ss_clear,
  output logic [1:0] fault_code
);
  import bfs_pkg::*;

  localparam int OV_CYCLES = ov_cycles(CLK_HZ, OV_DELAY_NS);

  sup_state_t state_q, state_d;
  logic sup_ok;
  logic ov_hit, uv_hit;
  logic armed;

  assign armed = (state_q == ST_RUN);

  bfs_supply_mon u_sup (
    .clk        (clk),
    .rst        (rst),
    .above_rise (vdd_above_rise),
    .above_fall (vdd_above_fall),
    .ok_o       (sup_ok)
  );

  bfs_ov_deglitch #(.CYCLES(OV_CYCLES)) u_ov (
    .clk  (clk),
    .rst  (rst),
    .arm  (armed),
    .flag (fb_over),
    .hit  (ov_hit)
  );

  bfs_uv_counter #(.TICKS(UV_TICKS)) u_uv (
    .clk  (clk),
    .rst  (rst),
    .arm  (armed),
    .tick (sw_tick),
    .flag (fb_under),
    .hit  (uv_hit)
  );

  // Next-state: lockout first, then latched faults, then enable, then
  // qualification with over-voltage ahead of under-voltage (R9).
  always_comb begin
    state_d = state_q;
    if (!sup_ok) begin
      state_d = ST_LOCK;
    end else if (!enable) begin
      state_d = ST_OFF;
    end else if (state_q == ST_OVP || state_q == ST_UVP) begin
      state_d = state_q;
    end else if (ov_hit) begin
      state_d = ST_OVP;
    end else if (uv_hit) begin
      state_d = ST_UVP;
    end else begin
      state_d = ST_RUN;
    end
  end

  // Registered outputs decoded from the next state.
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_LOCK;
      gate_hs    <= 1'b0;
      gate_ls    <= 1'b0;
      drv_hs_oe  <= 1'b0;
      drv_ls_oe  <= 1'b0;
      pgood      <= 1'b0;
      ss_clear   <= 1'b1;
      fault_code <= FC_NONE;
    end else begin
      state_q <= state_d;
      unique case (state_d)
        ST_RUN: begin
          gate_hs    <= pwm_hs_req;
          gate_ls    <= pwm_ls_req & ~pwm_hs_req;
          drv_hs_oe  <= 1'b1;
          drv_ls_oe  <= 1'b1;
          pgood      <= ~fb_over & ~fb_under;
          ss_clear   <= 1'b0;
          fault_code <= FC_NONE;
        end
        ST_OVP: begin
          gate_hs    <= 1'b0;
          gate_ls    <= 1'b1;
          drv_hs_oe  <= 1'b1;
          drv_ls_oe  <= 1'b1;
          pgood      <= 1'b0;
          ss_clear   <= 1'b1;
          fault_code <= FC_OVP;
        end
        ST_UVP: begin
          gate_hs    <= 1'b0;
          gate_ls    <= 1'b0;
          drv_hs_oe  <= 1'b0;
          drv_ls_oe  <= 1'b0;
          pgood      <= 1'b0;
          ss_clear   <= 1'b1;
          fault_code <= FC_UVP;
        end
        default: begin
          gate_hs    <= 1'b0;
          gate_ls    <= 1'b0;
          drv_hs_oe  <= 1'b0;
          drv_ls_oe  <= 1'b0;
          pgood      <= 1'b0;
          ss_clear   <= 1'b1;
          fault_code <= FC_NONE;
        end
      endcase
    end
  end

endmodule

// File: rtl/bfs_checker.sv
module bfs_checker (
  input logic       clk,
  input logic       rst,
  input logic       fb_over,
  input logic       enable,
  input logic       sup_ok,
  input logic       gate_hs,
  input logic       gate_ls,
  input logic       drv_hs_oe,
  input logic       drv_ls_oe,
  input logic       pgood,
  input logic       ss_clear,
  input logic [1:0] fault_code
);

  assert_lockout_tristate_R2: assert property (@(posedge clk) disable iff (rst)
    !sup_ok |=> (!drv_hs_oe && !drv_ls_oe && !gate_hs && !gate_ls));

  assert_no_shoot_through_R3: assert property (@(posedge clk) disable iff (rst)
    !(gate_hs && gate_ls));

  assert_ov_entry_needs_flag_R4: assert property (@(posedge clk) disable iff (rst)
    (fault_code == 2'b01 && $past(fault_code) != 2'b01) |-> $past(fb_over));

  assert_ovp_drive_R5: assert property (@(posedge clk) disable iff (rst)
    (fault_code == 2'b01) |-> (gate_ls && !gate_hs && drv_hs_oe && drv_ls_oe && !pgood));

  assert_uvp_tristate_R7: assert property (@(posedge clk) disable iff (rst)
    (fault_code == 2'b10) |-> (!gate_ls && !gate_hs && !drv_hs_oe && !drv_ls_oe && !pgood));

  assert_fault_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (fault_code != 2'b00 && enable && sup_ok) |=> (fault_code == $past(fault_code)));

  assert_code_legal_R9: assert property (@(posedge clk) disable iff (rst)
    fault_code != 2'b11);

  assert_ss_when_switching_R10: assert property (@(posedge clk) disable iff (rst)
    (gate_hs || pgood) |-> !ss_clear);

endmodule

bind buck_fault_supervisor bfs_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .fb_over    (fb_over),
  .enable     (enable),
  .sup_ok     (sup_ok),
  .gate_hs    (gate_hs),
  .gate_ls    (gate_ls),
  .drv_hs_oe  (drv_hs_oe),
  .drv_ls_oe  (drv_ls_oe),
  .pgood      (pgood),
  .ss_clear   (ss_clear),
  .fault_code (fault_code)
);

// File: tb/sim_buck_fault_supervisor.sv
`timescale 1ns/1ps
module sim_buck_fault_supervisor;

  localparam int OVC = 20;  // 4 MHz * 5 us

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sw_tick = 0, fb_over = 0, fb_under = 0;
  logic vdd_above_rise = 0, vdd_above_fall = 0, enable = 0;
  logic pwm_hs_req = 0, pwm_ls_req = 0;
  logic gate_hs, gate_ls, drv_hs_oe, drv_ls_oe, pgood, ss_clear;
  logic [1:0] fault_code;

  always #5 clk = ~clk;

  buck_fault_supervisor #(
    .CLK_HZ(4000000), .OV_DELAY_NS(5000), .UV_TICKS(8)
  ) u0 (
    .clk(clk), .rst(rst), .sw_tick(sw_tick), .fb_over(fb_over),
    .fb_under(fb_under), .vdd_above_rise(vdd_above_rise),
    .vdd_above_fall(vdd_above_fall), .enable(enable),
    .pwm_hs_req(pwm_hs_req), .pwm_ls_req(pwm_ls_req),
    .gate_hs(gate_hs), .gate_ls(gate_ls), .drv_hs_oe(drv_hs_oe),
    .drv_ls_oe(drv_ls_oe), .pgood(pgood), .ss_clear(ss_clear),
    .fault_code(fault_code)
  );

  // Vector: {hs, ls, hs_oe, ls_oe, pgood, ss_clear, code[1:0]}
  localparam logic [7:0] E_IDLE = 8'b0000_0100;
  localparam logic [7:0] E_OVP  = 8'b0111_0101;
  localparam logic [7:0] E_UVP  = 8'b0000_0110;

  function automatic logic [7:0] e_run(input logic hs, input logic ls, input logic pg);
    return {hs, ls, 2'b11, pg, 1'b0, 2'b00};
  endfunction

  logic [7:0] exp_q[$];
  string      tag_q[$];
  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // Driver side: push an expected vector for the current cycle.
  task automatic expect_out(input logic [7:0] v, input string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  // Monitor: compare just after each falling edge.
  always @(negedge clk) begin
    #1;
    while (exp_q.size() > 0) begin
      logic [7:0] e, a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = {gate_hs, gate_ls, drv_hs_oe, drv_ls_oe, pgood, ss_clear, fault_code};
      n_checks++;
      if (a !== e) begin
        n_fail++;
        $display("FAIL %s: actual %b expected %b", t, a, e);
      end
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sw_tick = 1'b1;
      @(negedge clk); sw_tick = 1'b0;
    end
  endtask

  task automatic finish_run;
    wait_n(2);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    wait_n(3);
    expect_out(E_IDLE, "R1 in reset");
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    expect_out(E_IDLE, "R1 after reset");

    // Supply up, enable low
    vdd_above_rise = 1; vdd_above_fall = 1; enable = 0;
    wait_n(3);
    expect_out(E_IDLE, "R11 enable low tristate");

    // Enable, run
    pwm_hs_req = 1; enable = 1;
    wait_n(1);
    expect_out(e_run(1, 0, 1), "R3 run hs");
    expect_out(e_run(1, 0, 1), "R10 ss_clear low in run");
    pwm_hs_req = 0; pwm_ls_req = 1;
    wait_n(1);
    expect_out(e_run(0, 1, 1), "R3 run ls");
    pwm_hs_req = 1;
    wait_n(1);
    expect_out(e_run(1, 0, 1), "R3 both requests guard");

    // Hysteresis
    vdd_above_rise = 0;
    wait_n(3);
    expect_out(e_run(1, 0, 1), "R2 between levels stays on");
    vdd_above_fall = 0;
    wait_n(2);
    expect_out(E_IDLE, "R2 below falling level locks out");
    vdd_above_fall = 1;
    wait_n(3);
    expect_out(E_IDLE, "R2 between levels stays locked");
    vdd_above_rise = 1;
    wait_n(2);
    expect_out(e_run(1, 0, 1), "R2 above rising level runs");

    // Over-voltage near miss then trip
    fb_over = 1;
    wait_n(OVC - 1);
    expect_out(e_run(1, 0, 0), "R4 short over-voltage no trip");
    fb_over = 0;
    wait_n(1);
    fb_over = 1;
    wait_n(OVC - 1);
    expect_out(e_run(1, 0, 0), "R4 restart after dropout");
    wait_n(1);
    expect_out(E_OVP, "R5 over-voltage latched");
    fb_over = 0;
    wait_n(5);
    expect_out(E_OVP, "R8 over-voltage held after flag clears");
    enable = 0;
    wait_n(1);
    expect_out(E_IDLE, "R8 enable low clears fault");
    enable = 1;
    wait_n(1);
    expect_out(e_run(1, 0, 1), "R8 restart after toggle");

    // Under-voltage with restart
    fb_under = 1;
    ticks(7);
    fb_under = 0;
    ticks(1);
    fb_under = 1;
    ticks(7);
    expect_out(e_run(1, 0, 0), "R6 seven ticks after restart no trip");
    ticks(1);
    expect_out(E_UVP, "R7 under-voltage latched");
    fb_under = 0;
    wait_n(4);
    expect_out(E_UVP, "R8 under-voltage held");
    vdd_above_fall = 0; vdd_above_rise = 0;
    wait_n(2);
    expect_out(E_IDLE, "R8 supply loss clears");
    vdd_above_fall = 1; vdd_above_rise = 1;
    wait_n(2);
    expect_out(e_run(1, 0, 1), "R8 power-on restart");

    // Both qualify on the same edge
    fb_under = 1;
    ticks(7);
    @(negedge clk); fb_over = 1;
    wait_n(OVC - 1);
    sw_tick = 1;
    @(negedge clk); sw_tick = 0;
    expect_out(E_OVP, "R9 over-voltage wins");
    expect_out(E_OVP, "R10 ss_clear high in fault");

    done = 1;
    finish_run();
  end

endmodule